// File: doc/BRIEF.md
# Failed Block Remap Controller

This controller sits between a requester and a memory built from 512-bit (64-byte) blocks. Some blocks have collected more permanent faults than their error correction can repair, and those blocks are retired. A retired block keeps a single remap flag bit. Its data area holds the address of its replacement block, written eight times. When a request arrives, the controller reads the addressed block. If the flag is set, it rebuilds the forwarding pointer by a bitwise majority vote over the copies. It then makes a second access to the replacement block, and that access serves the request.

A small, fully associative pointer cache is checked before any memory access. A request whose block mapping is already held there goes straight to the replacement block, so it needs one access instead of two. A retire command writes the replicated pointer into the failed block, sets its flag and places the mapping in the cache. The controller handles one request at a time. A request is taken over a ready/valid handshake, and a single-cycle response pulse ends it.

Top module: `remap_ctrl`

## Requirements
- R1: While reset is high and after it is released, `req_ready` is 1 and `resp_valid` and `mem_req` are 0. Reset also empties the pointer cache, so the first read of a retired block afterwards takes two memory accesses.
- R2: A read (`req_op` 2'b00, with 2'b11 treated the same) of a block whose flag is 0 makes one memory read at `req_addr`. It returns that block's data, with `resp_phys` = `req_addr` and `resp_cached` = 0.
- R3: A read of a flagged block that misses the cache makes two memory reads, first at `req_addr` and then at the recovered pointer. It returns the second block's data, with `resp_phys` equal to the pointer.
- R4: Pointer copy k sits at block bits [32k+31:32k] for k = 0..7. Bit b of the recovered pointer is 1 only when at least five of the eight copies have bit b set, so a 4-4 tie gives 0.
- R5: Once a mapping is known, a later access to the same address makes exactly one memory access, at the replacement block, and reports `resp_cached` = 1.
- R6: A write (`req_op` 2'b01) to an unflagged block that misses the cache first reads the block to learn its flag. It then writes `req_wdata` there with flag 0. A write to a flagged block goes to its replacement, and the failed block's contents and flag stay unchanged.
- R7: A retire (`req_op` 2'b10) makes one memory write at `req_addr`. Its data carries eight copies of `req_wdata[31:0]` in bits [255:0], zeros above, and flag 1. The mapping is then held in the cache, so the next read of that address takes one access.
- R8: The cache holds four mappings. A new mapping replaces the entry that was least recently used, and a mapping used more recently than the others survives.
- R9: `mem_req` stays high, with `mem_addr` and `mem_we` unchanged, until `mem_ack`. `req_ready` is low from the cycle after acceptance until the cycle after `resp_valid`.
- R10: `resp_valid` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_op | input | 2 | 00 read, 01 write, 10 retire, 11 read |
| req_addr | input | 32 | Block address |
| req_wdata | input | 512 | Write data; for retire, bits [31:0] hold the new target |
| resp_valid | output | 1 | Request finished (one cycle) |
| resp_rdata | output | 512 | Read data (valid for reads) |
| resp_phys | output | 32 | Block address that served the request |
| resp_cached | output | 1 | Mapping came from the pointer cache |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Memory block address |
| mem_wdata | output | 512 | Memory write data |
| mem_wflag | output | 1 | Remap flag value to write |
| mem_ack | input | 1 | Memory access done (read data valid) |
| mem_rdata | input | 512 | Memory read data |
| mem_rflag | input | 1 | Remap flag of the block read |

## Verification
The bench aims at the vote's edges. One failed block has three corrupted copies, which must still vote to the true pointer. Another splits its copies 5-3 on one bit, and a third splits 4-4, which must resolve to 0. A vote that rounds ties up, or trusts copy 0 alone, returns the wrong replacement block. The access count is checked on every request, so a design that skips the cache would show two accesses where one is expected. The cache is then filled past four entries. This shows whether the least recently used mapping is the one replaced, since a design that evicts a recently touched mapping loses a cache hit. Writes are checked in the bench's memory model: a write that lands in a failed block instead of its replacement, or that clears the flag, is caught there. A reset during a request must leave the controller idle with an empty cache.

// File: rtl/remap_pkg.sv
package remap_pkg;

    localparam int BLK_W   = 512;   // bits per memory block
    localparam int PTR_W   = 32;    // forwarding pointer width
    localparam int N_COPY  = 8;     // pointer copies in a retired block
    localparam int CACHE_N = 4;     // pointer cache entries

    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_RETIRE = 2'b10,
        OP_ALTRD  = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_READ1,
        S_DECODE,
        S_READ2,
        S_RESP
    } state_e;

    typedef struct packed {
        op_e  op;
        logic hit;
    } ctx_t;

    function automatic op_e norm_op(input logic [1:0] raw);
        return (raw == OP_ALTRD) ? OP_READ : op_e'(raw);
    endfunction

endpackage

// File: rtl/ptr_replicate.sv
module ptr_replicate #(
    parameter int BLK_W  = remap_pkg::BLK_W,
    parameter int PTR_W  = remap_pkg::PTR_W,
    parameter int N_COPY = remap_pkg::N_COPY
) (
    input  logic [PTR_W-1:0] ptr,
    output logic [BLK_W-1:0] blk
);
    localparam int CW  = N_COPY * PTR_W;
    localparam int PAD = BLK_W - CW;

    generate
        if (PAD > 0) begin : g_pad
            assign blk = {{PAD{1'b0}}, {N_COPY{ptr}}};
        end else begin : g_nopad
            assign blk = {N_COPY{ptr}};
        end
    endgenerate
endmodule

// File: rtl/ptr_vote.sv
module ptr_vote #(
    parameter int BLK_W  = remap_pkg::BLK_W,
    parameter int PTR_W  = remap_pkg::PTR_W,
    parameter int N_COPY = remap_pkg::N_COPY
) (
    input  logic [BLK_W-1:0] blk,
    output logic [PTR_W-1:0] ptr
);
    localparam int HALF = N_COPY / 2;

    generate
        for (genvar b = 0; b < PTR_W; b++) begin : g_bit
            logic [N_COPY-1:0] col;
            for (genvar k = 0; k < N_COPY; k++) begin : g_copy
                assign col[k] = blk[k*PTR_W + b];
            end
            // strict majority; an even split resolves to 0
            assign ptr[b] = ($countones(col) > HALF);
        end
    endgenerate
endmodule

// File: rtl/ptr_cache.sv
module ptr_cache #(
    parameter int PTR_W   = remap_pkg::PTR_W,
    parameter int CACHE_N = remap_pkg::CACHE_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PTR_W-1:0] lk_key,
    output logic             lk_hit,
    output logic [PTR_W-1:0] lk_tgt,
    input  logic             touch,
    input  logic             ins_en,
    input  logic [PTR_W-1:0] ins_key,
    input  logic [PTR_W-1:0] ins_tgt
);
    localparam int IW = (CACHE_N > 1) ? $clog2(CACHE_N) : 1;

    logic [CACHE_N-1:0] vld;
    logic [PTR_W-1:0]   key [CACHE_N];
    logic [PTR_W-1:0]   tgt [CACHE_N];
    logic [IW-1:0]      age [CACHE_N];

    logic [CACHE_N-1:0] match, ins_match, age_zero;
    logic [IW-1:0]      hit_idx, ins_idx, acc_idx;
    logic               ins_hit, free_found, acc_en;

    always_comb begin
        lk_tgt  = '0;
        hit_idx = '0;
        for (int i = 0; i < CACHE_N; i++) begin
            match[i]     = vld[i] && (key[i] == lk_key);
            ins_match[i] = vld[i] && (key[i] == ins_key);
            age_zero[i]  = (age[i] == '0);
            if (match[i]) begin
                lk_tgt  = lk_tgt | tgt[i];
                hit_idx = IW'(i);
            end
        end
        lk_hit = |match;
    end

    // slot for an install: existing entry, else first empty, else oldest
    always_comb begin
        ins_hit    = 1'b0;
        free_found = 1'b0;
        ins_idx    = '0;
        for (int i = 0; i < CACHE_N; i++) begin
            if (ins_match[i]) begin
                ins_hit = 1'b1;
                ins_idx = IW'(i);
            end
        end
        if (!ins_hit) begin
            for (int i = 0; i < CACHE_N; i++) begin
                if (!vld[i] && !free_found) begin
                    free_found = 1'b1;
                    ins_idx    = IW'(i);
                end
            end
            if (!free_found) begin
                for (int i = 0; i < CACHE_N; i++) begin
                    if (age[i] == IW'(CACHE_N - 1)) ins_idx = IW'(i);
                end
            end
        end
    end

    assign acc_en  = ins_en || (touch && lk_hit);
    assign acc_idx = ins_en ? ins_idx : hit_idx;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            for (int i = 0; i < CACHE_N; i++) begin
                key[i] <= '0;
                tgt[i] <= '0;
                age[i] <= IW'(i);
            end
        end else begin
            if (ins_en) begin
                vld[ins_idx] <= 1'b1;
                key[ins_idx] <= ins_key;
                tgt[ins_idx] <= ins_tgt;
            end
            if (acc_en) begin
                for (int j = 0; j < CACHE_N; j++) begin
                    if (IW'(j) == acc_idx)        age[j] <= '0;
                    else if (age[j] < age[acc_idx]) age[j] <= age[j] + IW'(1);
                end
            end
        end
    end

    AST_CACHE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match)); // R8
    AST_ONE_MRU: assert property (@(posedge clk) disable iff (rst)
        $onehot(age_zero)); // R8
    AST_NO_TOUCH_INSTALL: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !touch); // R8
    AST_INSTALL_VISIBLE: assert property (@(posedge clk) disable iff (rst)
        ins_en && (lk_key == ins_key) |=> lk_hit && (lk_tgt == $past(ins_tgt))); // R5
endmodule

// File: rtl/remap_ctrl.sv
module remap_ctrl
    import remap_pkg::*;
#(
    parameter int BLK_W   = remap_pkg::BLK_W,
    parameter int PTR_W   = remap_pkg::PTR_W,
    parameter int N_COPY  = remap_pkg::N_COPY,
    parameter int CACHE_N = remap_pkg::CACHE_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_op,
    input  logic [PTR_W-1:0] req_addr,
    input  logic [BLK_W-1:0] req_wdata,
    output logic             resp_valid,
    output logic [BLK_W-1:0] resp_rdata,
    output logic [PTR_W-1:0] resp_phys,
    output logic             resp_cached,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PTR_W-1:0] mem_addr,
    output logic [BLK_W-1:0] mem_wdata,
    output logic             mem_wflag,
    input  logic             mem_ack,
    input  logic [BLK_W-1:0] mem_rdata,
    input  logic             mem_rflag
);
    localparam int CW = N_COPY * PTR_W;

    state_e           st;
    ctx_t             ctx_q;
    op_e              in_op;
    logic [PTR_W-1:0] addr_q, phys_q;
    logic [BLK_W-1:0] wdata_q, rdat_q;
    logic             rflag_q;

    logic [PTR_W-1:0] voted, lk_tgt, ins_tgt;
    logic [BLK_W-1:0] repl_blk;
    logic             lk_hit, touch, ins_en;

    assign in_op = norm_op(req_op);

    ptr_vote #(.BLK_W(BLK_W), .PTR_W(PTR_W), .N_COPY(N_COPY)) u_vote (
        .blk (rdat_q),
        .ptr (voted)
    );

    ptr_replicate #(.BLK_W(BLK_W), .PTR_W(PTR_W), .N_COPY(N_COPY)) u_repl (
        .ptr (wdata_q[PTR_W-1:0]),
        .blk (repl_blk)
    );

    assign touch   = (st == S_IDLE) && req_valid && (in_op != OP_RETIRE);
    assign ins_en  = ((st == S_DECODE) && rflag_q) ||
                     ((st == S_READ2) && mem_ack && (ctx_q.op == OP_RETIRE));
    assign ins_tgt = (st == S_DECODE) ? voted : wdata_q[PTR_W-1:0];

    ptr_cache #(.PTR_W(PTR_W), .CACHE_N(CACHE_N)) u_cache (
        .clk     (clk),
        .rst     (rst),
        .lk_key  (req_addr),
        .lk_hit  (lk_hit),
        .lk_tgt  (lk_tgt),
        .touch   (touch),
        .ins_en  (ins_en),
        .ins_key (addr_q),
        .ins_tgt (ins_tgt)
    );

    // request side
    assign req_ready   = (st == S_IDLE);
    assign resp_valid  = (st == S_RESP);
    assign resp_rdata  = rdat_q;
    assign resp_phys   = phys_q;
    assign resp_cached = ctx_q.hit;

    // memory side
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = addr_q;
        mem_wdata = wdata_q;
        mem_wflag = 1'b0;
        if (st == S_READ1) begin
            mem_req = 1'b1;
        end else if (st == S_READ2) begin
            mem_req  = 1'b1;
            mem_addr = phys_q;
            mem_we   = (ctx_q.op != OP_READ);
            if (ctx_q.op == OP_RETIRE) begin
                mem_wdata = repl_blk;
                mem_wflag = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            ctx_q   <= '{op: OP_READ, hit: 1'b0};
            addr_q  <= '0;
            phys_q  <= '0;
            wdata_q <= '0;
            rdat_q  <= '0;
            rflag_q <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: if (req_valid) begin
                    ctx_q.op <= in_op;
                    addr_q   <= req_addr;
                    wdata_q  <= req_wdata;
                    if (in_op == OP_RETIRE) begin
                        ctx_q.hit <= 1'b0;
                        phys_q    <= req_addr;
                        st        <= S_READ2;
                    end else if (lk_hit) begin
                        ctx_q.hit <= 1'b1;
                        phys_q    <= lk_tgt;
                        st        <= S_READ2;
                    end else begin
                        ctx_q.hit <= 1'b0;
                        phys_q    <= req_addr;
                        st        <= S_READ1;
                    end
                end
                S_READ1: if (mem_ack) begin
                    rdat_q  <= mem_rdata;
                    rflag_q <= mem_rflag;
                    st      <= S_DECODE;
                end
                S_DECODE: begin
                    if (rflag_q) begin
                        phys_q <= voted;
                        st     <= S_READ2;
                    end else if (ctx_q.op == OP_READ) begin
                        st <= S_RESP;
                    end else begin
                        st <= S_READ2;
                    end
                end
                S_READ2: if (mem_ack) begin
                    if (ctx_q.op == OP_READ) rdat_q <= mem_rdata;
                    st <= S_RESP;
                end
                S_RESP: st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R9
    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid && req_ready); // R10
    AST_FLAG_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
        mem_wflag |-> mem_req && mem_we); // R7
    AST_HIT_SKIPS_READ1: assert property (@(posedge clk) disable iff (rst)
        (st == S_READ1) |-> !ctx_q.hit); // R5
    AST_VOTE_UNANIMOUS: assert property (@(posedge clk) disable iff (rst)
        (st == S_DECODE) && (rdat_q[CW-1:0] == {N_COPY{rdat_q[PTR_W-1:0]}})
        |-> (voted == rdat_q[PTR_W-1:0])); // R4
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        req_ready && req_valid |=> !req_ready && !resp_valid); // R9
endmodule

// File: tb/sim_remap_ctrl.sv
module sim_remap_ctrl;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] ptr;
        logic [31:0] phys;
        logic        cached;
        logic [3:0]  nacc;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t [0:NV-1] VEC = '{
        '{2'd0, 32'd3,  32'd0,  32'd3,  1'b0, 4'd1},  // R2 plain read
        '{2'd0, 32'd10, 32'd0,  32'd40, 1'b0, 4'd2},  // R3 remap miss
        '{2'd0, 32'd10, 32'd0,  32'd40, 1'b1, 4'd1},  // R5 cached
        '{2'd0, 32'd11, 32'd0,  32'd41, 1'b0, 4'd2},  // R4 corrupted copies
        '{2'd0, 32'd12, 32'd0,  32'd43, 1'b0, 4'd2},  // R4 5-3 split
        '{2'd0, 32'd13, 32'd0,  32'd44, 1'b0, 4'd2},  // R4 4-4 tie
        '{2'd1, 32'd5,  32'd0,  32'd5,  1'b0, 4'd2},  // R6 write, plain
        '{2'd1, 32'd10, 32'd0,  32'd40, 1'b1, 4'd1},  // R6 write, remapped
        '{2'd2, 32'd20, 32'd50, 32'd20, 1'b0, 4'd1},  // R7 retire
        '{2'd0, 32'd20, 32'd0,  32'd50, 1'b1, 4'd1},  // R7 retired hit
        '{2'd0, 32'd11, 32'd0,  32'd41, 1'b0, 4'd2},  // R8 evicted
        '{2'd0, 32'd10, 32'd0,  32'd40, 1'b1, 4'd1},  // R8 survivor
        '{2'd3, 32'd7,  32'd0,  32'd7,  1'b0, 4'd1},  // R2 op 11 reads
        '{2'd0, 32'd12, 32'd0,  32'd43, 1'b0, 4'd2}   // R8 second eviction
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [1:0]   req_op = 2'd0;
    logic [31:0]  req_addr = '0;
    logic [511:0] req_wdata = '0;
    logic         resp_valid;
    logic [511:0] resp_rdata;
    logic [31:0]  resp_phys;
    logic         resp_cached;
    logic         mem_req, mem_we, mem_wflag;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata;
    logic         mem_ack;
    logic [511:0] mem_rdata;
    logic         mem_rflag;

    int n_tests = 0;
    int n_fail  = 0;
    int acc_total = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    remap_ctrl u0 (.*);

    // ---------------- memory model ----------------
    logic [511:0] mdat  [64];
    logic         mflag [64];
    logic [2:0]   mcnt;

    function automatic logic [511:0] pat(input int idx);
        return {16{32'h5A00_0000 + 32'(idx) * 32'h0001_0001}};
    endfunction

    function automatic logic [511:0] copies(input logic [31:0] p [8]);
        logic [511:0] b = '0;
        for (int k = 0; k < 8; k++) b[k*32 +: 32] = p[k];
        return b;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            logic [31:0] p [8];
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
            mem_rflag <= 1'b0;
            mcnt      <= '0;
            for (int i = 0; i < 64; i++) begin
                mdat[i]  <= pat(i);
                mflag[i] <= 1'b0;
            end
            for (int k = 0; k < 8; k++) p[k] = 32'd40;
            mdat[10] <= copies(p); mflag[10] <= 1'b1;
            for (int k = 0; k < 8; k++) p[k] = 32'd41;
            p[5] = 32'd41 ^ 32'hFFFF_0000;
            p[6] = 32'd41 ^ 32'h0000_00FF;
            p[7] = 32'd41 ^ 32'h8000_0001;
            mdat[11] <= copies(p); mflag[11] <= 1'b1;
            for (int k = 0; k < 8; k++) p[k] = (k < 5) ? 32'd43 : 32'd42;
            mdat[12] <= copies(p); mflag[12] <= 1'b1;
            for (int k = 0; k < 8; k++) p[k] = (k < 4) ? 32'd45 : 32'd44;
            mdat[13] <= copies(p); mflag[13] <= 1'b1;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (mcnt == 3'd1 + {1'b0, mem_addr[1:0]}) begin
                mem_ack <= 1'b1;
                mcnt    <= '0;
                if (mem_we) begin
                    mdat[mem_addr[5:0]]  <= mem_wdata;
                    mflag[mem_addr[5:0]] <= mem_wflag;
                end else begin
                    mem_rdata <= mdat[mem_addr[5:0]];
                    mem_rflag <= mflag[mem_addr[5:0]];
                end
            end else begin
                mcnt <= mcnt + 3'd1;
            end
        end
    end

    always @(posedge clk) if (mem_ack) acc_total <= acc_total + 1;

    // ---------------- checking helpers ----------------
    task automatic chk(input bit ok, input string req,
                       input logic [511:0] act, input logic [511:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run(input logic [1:0] op, input logic [31:0] addr,
                       input logic [511:0] wd, output logic [31:0] phys,
                       output logic cached, output logic [511:0] rd,
                       output int nacc);
        int start;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        start = acc_total;
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R9 busy after accept", 512'(req_ready), 512'd0);
        while (!resp_valid) @(negedge clk);
        phys = resp_phys; cached = resp_cached; rd = resp_rdata;
        nacc = acc_total - start;
        @(negedge clk);
        chk(resp_valid == 1'b0, "R10 single-cycle response", 512'(resp_valid), 512'd0);
        chk(req_ready == 1'b1, "R9 ready after response", 512'(req_ready), 512'd1);
    endtask

    // ---------------- watchdog ----------------
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 100000) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        logic [31:0]  phys;
        logic         cached;
        logic [511:0] rd;
        logic [511:0] wv [NV];
        logic [31:0]  p50 [8];
        int           nacc;

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", 512'(req_ready), 512'd1);
        chk(resp_valid == 1'b0 && mem_req == 1'b0, "R1 idle outputs in reset",
            512'({resp_valid, mem_req}), 512'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && mem_req == 1'b0, "R1 idle after reset",
            512'({req_ready, mem_req}), 512'b10);

        for (int v = 0; v < NV; v++) begin
            wv[v] = (VEC[v].op == 2'd2) ? {480'd0, VEC[v].ptr}
                                        : {16{32'hC0DE_0000 + 32'(v)}};
            run(VEC[v].op, VEC[v].addr, wv[v], phys, cached, rd, nacc);
            chk(phys == VEC[v].phys, $sformatf("vector %0d phys (R2 R3 R4 R6 R7)", v),
                512'(phys), 512'(VEC[v].phys));
            chk(cached == VEC[v].cached, $sformatf("vector %0d cached (R5 R8)", v),
                512'(cached), 512'(VEC[v].cached));
            chk(nacc == int'(VEC[v].nacc), $sformatf("vector %0d accesses (R3 R5 R8)", v),
                512'(nacc), 512'(VEC[v].nacc));
            if (VEC[v].op == 2'd0 || VEC[v].op == 2'd3)
                chk(rd == mdat[VEC[v].phys[5:0]], $sformatf("vector %0d read data (R2 R3)", v),
                    rd, mdat[VEC[v].phys[5:0]]);
        end

        // R6: write landing places and untouched failed block
        chk(mdat[5] == wv[6] && mflag[5] == 1'b0, "R6 plain write stored",
            mdat[5], wv[6]);
        chk(mdat[40] == wv[7], "R6 write went to replacement", mdat[40], wv[7]);
        chk(mflag[10] == 1'b1 && mdat[10][31:0] == 32'd40, "R6 failed block unchanged",
            mdat[10], 512'd0);
        // R7: retire layout
        for (int k = 0; k < 8; k++) p50[k] = 32'd50;
        chk(mdat[20] == copies(p50) && mflag[20] == 1'b1, "R7 retire layout",
            mdat[20], copies(p50));

        // R1: reset in the middle of a request empties the cache
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd0; req_addr = 32'd11;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1 && resp_valid == 1'b0 && mem_req == 1'b0,
            "R1 idle after mid-request reset",
            512'({req_ready, resp_valid, mem_req}), 512'b100);
        run(2'd0, 32'd10, '0, phys, cached, rd, nacc);
        chk(cached == 1'b0 && nacc == 2, "R1 cache cleared by reset",
            512'({cached, 4'(nacc)}), 512'({1'b0, 4'd2}));
        chk(phys == 32'd40, "R3 remap after reset", 512'(phys), 512'd40);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule